// File: doc/BRIEF.md
# Serial Output Expander Controller

This block controls an external 8-bit serial-in, parallel-out shift register that has an output latch. It uses four lines for this: serial data, shift clock, storage clock and an active-low output enable. The block keeps a shadow copy of the eight latched outputs. A host sends a command over a valid/ready request channel. The command names one output index and a level. The block changes only that bit in the shadow, shifts the whole byte out most-significant bit first, and then pulses the storage clock so the external register copies the byte to its outputs.

A second command kind produces a reset pulse on one output. The block sends two latched frames back to back. In the first frame the chosen output is at its asserted level and every other output is at its idle level. In the second frame every output is at its idle level. Outputs 1 and 2 are active-low reset lines, so they idle high and pulse low. All the others idle low.

A programmable half-period sets the length of each clock phase in system clocks. The request channel has no buffering. The ready signal is the inverse of busy, so the host has to hold a request until it is accepted. A request raised while the block is busy is not taken, and it leaves no trace once it is withdrawn.

Top module: `serexp_ctrl`

## Requirements
- R1: While reset is asserted, the shadow byte is 0x00, shift_clk and store_clk are high, ser_data is 0, busy and done are low, and out_en_n is high.
- R2: req_ready is high exactly when busy is low. A request is taken at a rising edge where req_valid and req_ready are both high. A request presented while busy changes nothing: shadow, the serial lines, busy and done all behave as if it were absent.
- R3: In set mode (req_pulse=0), shadow bit req_pin becomes req_level. The other seven bits keep their values. The new shadow is visible from the first cycle after acceptance.
- R4: A frame shifts 8 bits, bit 7 first and bit 0 last. For each bit, shift_clk is low for H cycles with ser_data showing the bit, then high for H cycles. H is half_period, and a half_period of 0 acts as 1. ser_data changes only on the edge where shift_clk falls.
- R5: After the eighth high phase, store_clk is low for H cycles and then rises. A single frame lasts 17·H cycles from acceptance. On the cycle store_clk rises for the last time in a command, busy falls and done is high for exactly one cycle.
- R6: In pulse mode (req_pulse=1), req_level is ignored. Frame one is the idle word 0x06 (bits 1 and 2 high) with bit req_pin inverted. Frame two is 0x06 and begins shifting on the same edge where frame one's store_clk rises. The shadow becomes 0x06, and a pulse command lasts 34·H cycles.
- R7: From the first clock edge after reset is released, out_en_n is low.
- R8: Whenever busy is low, shift_clk and store_clk are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_period | input | 16 | Clock phase length in system clocks (0 acts as 1); hold stable while busy |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | Command can be accepted |
| req_pin | input | 3 | Output index to change |
| req_level | input | 1 | Level for set mode |
| req_pulse | input | 1 | 1 = reset-pulse command, 0 = set command |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| ser_data | output | 1 | Serial data to the external register |
| shift_clk | output | 1 | Shift clock, idles high |
| store_clk | output | 1 | Storage (latch) clock, idles high |
| out_en_n | output | 1 | Active-low output enable for the external register |
| shadow | output | 8 | Shadow copy of the latched outputs |

## Verification
Every result follows a fixed count from the acceptance edge. The new shadow, shift_clk low and bit 7 on ser_data all appear in the first cycle after acceptance. Each later clock phase starts H cycles after the previous one. store_clk rises, busy falls and done strobes 17·H cycles after acceptance for a set command, and 34·H cycles after acceptance for a pulse command. The bench model turns every accepted command into a per-cycle list of expected line values, using H as it stood at acceptance. It pops one entry at every rising edge and compares all outputs at the following falling edge, so timing errors of a single cycle are caught.

// File: rtl/serexp_pkg.sv
package serexp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SHLO  = 2'd1,
    PH_SHHI  = 2'd2,
    PH_STLO  = 2'd3
  } phase_e;
endpackage

// File: rtl/serexp_divider.sv
module serexp_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] half,
  output logic             expire
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (half == '0) ? '0 : half - DIV_W'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - DIV_W'(1);
    end
  end

  assign expire = (cnt == '0);
endmodule

// File: rtl/serexp_shadow.sv
module serexp_shadow #(
  parameter int               NBITS     = 8,
  parameter int               IDX_W     = 3,
  parameter logic [NBITS-1:0] IDLE_WORD = 8'h06
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [IDX_W-1:0] pin,
  input  logic             level,
  input  logic             pulse,
  output logic [NBITS-1:0] shadow,
  output logic [NBITS-1:0] first_word
);
  logic [NBITS-1:0] updated;
  logic [NBITS-1:0] flipped;

  always_comb begin
    updated      = shadow;
    updated[pin] = level;
    flipped      = IDLE_WORD;
    flipped[pin] = ~IDLE_WORD[pin];
    first_word   = pulse ? flipped : updated;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
    end else if (accept) begin
      shadow <= pulse ? IDLE_WORD : updated;
    end
  end
endmodule

// File: rtl/serexp_seq.sv
module serexp_seq
  import serexp_pkg::*;
#(
  parameter int               NBITS     = 8,
  parameter logic [NBITS-1:0] IDLE_WORD = 8'h06
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_pulse,
  input  logic [NBITS-1:0] start_word,
  input  logic             expire,
  output logic             load,
  output logic             busy,
  output logic             done,
  output logic             ser_data,
  output logic             shift_clk,
  output logic             store_clk
);
  localparam int BIT_W = $clog2(NBITS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(NBITS - 1);

  phase_e           phase;
  logic [NBITS-1:0] shreg;
  logic [BIT_W-1:0] bitc;
  logic             second;
  logic             advance;

  assign advance  = (phase != PH_IDLE) && expire;
  assign load     = start || advance;
  assign busy     = (phase != PH_IDLE);
  assign ser_data = shreg[NBITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      shreg     <= '0;
      bitc      <= '0;
      second    <= 1'b0;
      done      <= 1'b0;
      shift_clk <= 1'b1;
      store_clk <= 1'b1;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) begin
          phase     <= PH_SHLO;
          shreg     <= start_word;
          bitc      <= '0;
          second    <= start_pulse;
          shift_clk <= 1'b0;
        end
        PH_SHLO: if (advance) begin
          phase     <= PH_SHHI;
          shift_clk <= 1'b1;
        end
        PH_SHHI: if (advance) begin
          if (bitc == LAST_BIT) begin
            phase     <= PH_STLO;
            store_clk <= 1'b0;
          end else begin
            phase     <= PH_SHLO;
            shift_clk <= 1'b0;
            bitc      <= bitc + BIT_W'(1);
            shreg     <= {shreg[NBITS-2:0], 1'b0};
          end
        end
        PH_STLO: if (advance) begin
          store_clk <= 1'b1;
          if (second) begin
            second    <= 1'b0;
            phase     <= PH_SHLO;
            shreg     <= IDLE_WORD;
            bitc      <= '0;
            shift_clk <= 1'b0;
          end else begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serexp_ctrl.sv
module serexp_ctrl #(
  parameter int        NBITS     = 8,
  parameter int        DIV_W     = 16,
  parameter logic [NBITS-1:0] IDLE_WORD = 8'h06,
  localparam int       IDX_W     = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_period,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] req_pin,
  input  logic             req_level,
  input  logic             req_pulse,
  output logic             busy,
  output logic             done,
  output logic             ser_data,
  output logic             shift_clk,
  output logic             store_clk,
  output logic             out_en_n,
  output logic [NBITS-1:0] shadow
);
  logic             accept;
  logic             load;
  logic             expire;
  logic [NBITS-1:0] first_word;

  assign req_ready = ~busy;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_en_n <= 1'b1;
    else        out_en_n <= 1'b0;
  end

  serexp_shadow #(.NBITS(NBITS), .IDX_W(IDX_W), .IDLE_WORD(IDLE_WORD)) u_shadow (
    .clk(clk), .rst_n(rst_n), .accept(accept), .pin(req_pin), .level(req_level),
    .pulse(req_pulse), .shadow(shadow), .first_word(first_word)
  );

  serexp_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .load(load), .half(half_period), .expire(expire)
  );

  serexp_seq #(.NBITS(NBITS), .IDLE_WORD(IDLE_WORD)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .start_pulse(req_pulse),
    .start_word(first_word), .expire(expire), .load(load), .busy(busy),
    .done(done), .ser_data(ser_data), .shift_clk(shift_clk), .store_clk(store_clk)
  );
endmodule

// File: rtl/serexp_ctrl_chk.sv
module serexp_ctrl_chk #(
  parameter int NBITS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             ser_data,
  input logic             shift_clk,
  input logic             store_clk,
  input logic             out_en_n,
  input logic [NBITS-1:0] shadow
);
  a_r7_oe_held: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en_n |=> !out_en_n);
  a_r2_busy_shadow_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(shadow));
  a_r4_data_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_clk) |-> $stable(ser_data));
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_done_with_latch: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($rose(store_clk) && !busy));
  a_r5_latch_low_shift_high: assert property (@(posedge clk) disable iff (!rst_n)
    !store_clk |-> shift_clk);
  a_r8_idle_clocks_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (shift_clk && store_clk));
endmodule

bind serexp_ctrl serexp_ctrl_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .ser_data(ser_data),
  .shift_clk(shift_clk), .store_clk(store_clk), .out_en_n(out_en_n), .shadow(shadow)
);

// File: tb/test_serexp_ctrl.sv
module test_serexp_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] half_period = 16'd2;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_pin = 3'd0;
  logic        req_level = 1'b0;
  logic        req_pulse = 1'b0;
  logic        busy, done, ser_data, shift_clk, store_clk, out_en_n;
  logic [7:0]  shadow;

  localparam logic [7:0] IDLE_W = 8'h06;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  // expected line entry: [0]shift [1]store [2]data [3]busy [4]done
  logic [4:0] q[$];
  logic [4:0] cur = 5'b00011;
  logic [7:0] m_shadow = 8'h00;
  bit         out_of_reset = 0;

  always #2 clk = ~clk;

  serexp_ctrl i_serexp_ctrl (
    .clk(clk), .rst_n(rst_n), .half_period(half_period), .req_valid(req_valid),
    .req_ready(req_ready), .req_pin(req_pin), .req_level(req_level),
    .req_pulse(req_pulse), .busy(busy), .done(done), .ser_data(ser_data),
    .shift_clk(shift_clk), .store_clk(store_clk), .out_en_n(out_en_n), .shadow(shadow)
  );

  task automatic push_frame(input logic [7:0] w, input int h, input bit last);
    for (int b = 7; b >= 0; b--) begin
      for (int k = 0; k < h; k++) q.push_back({2'b01, w[b], 2'b10});
      for (int k = 0; k < h; k++) q.push_back({2'b01, w[b], 2'b11});
    end
    for (int k = 0; k < h; k++) q.push_back({2'b01, w[0], 2'b01});
    if (last) q.push_back({2'b10, w[0], 2'b11});
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      cur = 5'b00011;
      m_shadow = 8'h00;
      out_of_reset = 0;
    end else begin
      out_of_reset = 1;
      if (q.size() == 0 && req_valid) begin
        int h;
        logic [7:0] w;
        h = (half_period == 0) ? 1 : int'(half_period);
        if (req_pulse) begin
          w = IDLE_W;
          w[req_pin] = ~IDLE_W[req_pin];
          m_shadow = IDLE_W;
          push_frame(w, h, 0);
          push_frame(IDLE_W, h, 1);
        end else begin
          m_shadow[req_pin] = req_level;
          push_frame(m_shadow, h, 1);
        end
      end
      if (q.size() > 0) cur = q.pop_front();
      else cur = {2'b00, cur[2], 2'b11};
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp_v);
    compared++;
    if (act != exp_v) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    chk(cur[3] ? "R4" : "R8", "shift_clk", int'(shift_clk), int'(cur[0]));
    chk("R5", "store_clk", int'(store_clk), int'(cur[1]));
    chk("R4", "ser_data", int'(ser_data), int'(cur[2]));
    chk("R5", "busy", int'(busy), int'(cur[3]));
    chk("R5", "done", int'(done), int'(cur[4]));
    chk("R2", "req_ready", int'(req_ready), int'(!cur[3]));
    chk(m_shadow == shadow ? "R3" : (cur[3] ? "R6" : "R3"), "shadow", int'(shadow), int'(m_shadow));
    if (!rst_n) chk("R1", "out_en_n", int'(out_en_n), 1);
    else if (out_of_reset) chk("R7", "out_en_n", int'(out_en_n), 0);
  end

  task automatic send(input logic [2:0] pin, input logic lvl, input logic pul, input logic [15:0] h);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    half_period = h;
    req_pin = pin; req_level = lvl; req_pulse = pul; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset values observed by the per-cycle compare while rst_n is low
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    send(3'd5, 1'b1, 1'b0, 16'd2);        // R3 set, H=2
    // R2: a request while busy that would change shadow bit 3
    repeat (5) @(negedge clk);
    req_pin = 3'd3; req_level = 1'b1; req_pulse = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    send(3'd1, 1'b1, 1'b0, 16'd1);        // R3 set index 1
    wait_idle();
    send(3'd1, 1'b0, 1'b1, 16'd3);        // R6 pulse active-low line
    wait_idle();
    send(3'd6, 1'b0, 1'b1, 16'd1);        // R6 pulse active-high line
    wait_idle();
    send(3'd7, 1'b1, 1'b0, 16'd0);        // R4 H=0 acts as 1
    wait_idle();
    send(3'd7, 1'b0, 1'b0, 16'd1);        // R3 clear bit 7
    send(3'd0, 1'b1, 1'b0, 16'd1);        // R2 back-to-back
    wait_idle();
    send(3'd2, 1'b1, 1'b1, 16'd2);        // R6 level ignored
    wait_idle();
    finish_run();
  end

  initial begin
    wait (cycles > 20000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    finish_run();
  end
endmodule